// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block finds a setting for a fractional-free clock synthesizer: an input divider, a feedback multiplier and an output divider. The synthesized frequency is the reference divided by the input divider, times the multiplier, divided by the output divider. A single start pulse latches a target frequency and a reference frequency, both in kHz. The engine then walks every legal combination, one candidate per step, and keeps the one whose frequency lies closest to the target.

A single iterative divider, a few bits per cycle, computes each candidate's frequency. The engine stops as soon as it meets an exact match. Otherwise it finishes the whole sweep and accepts the best candidate only if its error stays under a fixed tolerance. A one-cycle done pulse marks the result. The found flag, the three parameters and the best error then hold steady until the next search starts.

Top module: `pll_param_search`

## Requirements
- R1: A candidate's frequency is computed in this order: the reference divided by the input divider (truncated), times the multiplier, then divided by the output divider (truncated). For example, reference 100000 with input divider 3, multiplier 36 and output divider 6 yields 199998.
- R2: Candidates are visited with the output divider in the outer loop (6 up to 63), the input divider in the middle loop (3 up to 5) and the multiplier in the inner loop (6 up to 160), each counting upward.
- R3: A candidate is evaluated only when its multiplier lies between 12 and 32 times its input divider, both ends included.
- R4: The stored best error starts at the tolerance of 1000 kHz. A candidate replaces the stored best only when its absolute error is strictly smaller, so among equal errors the earliest candidate in visit order wins.
- R5: A candidate with zero error ends the search at once, reporting found = 1, error 0 and that candidate's parameters, within a few dozen cycles when it is the first candidate.
- R6: After a complete sweep, found is 1 only if the best error is below 1000. When no candidate beats the tolerance, found is 0, the error output is 1000 and all three parameter outputs are 0.
- R7: The absolute error is the larger of target and computed frequency minus the smaller, with no wrap.
- R8: done is high for exactly one cycle at the end of each search.
- R9: A start pulse that arrives while a search is running is ignored; the running search completes with its original target and reference.
- R10: After reset, every output is 0. Between searches, the result outputs keep their values even if the target or reference inputs change without a start.
- R11: The reference frequency is an input latched at start. The usual value is 100000 kHz, but other values are honoured. For example, reference 60000 with target 120000 matches exactly on the first candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that launches a search when idle |
| target_khz_i | input | FREQ_W | Wanted output frequency in kHz |
| ref_khz_i | input | FREQ_W | Reference frequency in kHz |
| done_o | output | 1 | One-cycle pulse when a search ends |
| found_o | output | 1 | Result meets the tolerance |
| div_out_o | output | 6 | Chosen output divider |
| div_ref_o | output | 3 | Chosen input divider |
| mult_o | output | 8 | Chosen feedback multiplier |
| err_khz_o | output | FREQ_W+8 | Absolute error of the chosen candidate in kHz |

## Verification
The assertions assume the target and the reference stay within FREQ_W bits. They also assume the reference is large enough that the quotient of the first division times the multiplier fits in the product width. Under these limits the divider remainder bound and the tolerance relations on the result always hold. The stimulus uses references of 100000 and 60000 kHz with targets below 1 MHz. It pulses start only for one cycle and, apart from the deliberate busy-start test, only while the engine is idle. A bench-side model of the full sweep computes each expected result.

// File: rtl/plldiv_pkg.sv
package plldiv_pkg;

    localparam int unsigned DO_W = 6;
    localparam int unsigned DR_W = 3;
    localparam int unsigned LC_W = 8;

    typedef struct packed {
        logic [DO_W-1:0] dout;
        logic [DR_W-1:0] dref;
        logic [LC_W-1:0] mult;
    } pll_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_REF      = 3'd1,
        S_REF_WAIT = 3'd2,
        S_OUT      = 3'd3,
        S_OUT_WAIT = 3'd4
    } srch_state_t;

    // lowest multiplier allowed for a given input divider
    function automatic logic [LC_W-1:0] win_lo(input int unsigned dr,
                                               input int unsigned lc_min,
                                               input int unsigned ratio);
        int unsigned v;
        v = ratio * dr;
        if (v < lc_min) v = lc_min;
        return LC_W'(v);
    endfunction

    // highest multiplier allowed for a given input divider
    function automatic logic [LC_W-1:0] win_hi(input int unsigned dr,
                                               input int unsigned lc_max,
                                               input int unsigned ratio);
        int unsigned v;
        v = ratio * dr;
        if (v > lc_max) v = lc_max;
        return LC_W'(v);
    endfunction

endpackage

// File: rtl/plldiv_divider.sv
module plldiv_divider #(
    parameter int unsigned NUM_W    = 28,
    parameter int unsigned DEN_W    = 6,
    parameter int unsigned DIV_STEP = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int unsigned PASSES = (NUM_W + DIV_STEP - 1) / DIV_STEP;
    localparam int unsigned NP     = PASSES * DIV_STEP;
    localparam int unsigned CNT_W  = $clog2(PASSES + 1);

    logic [NP-1:0]    quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;

    logic [NP-1:0]    qs [0:DIV_STEP];
    logic [DEN_W-1:0] rs [0:DIV_STEP];

    assign qs[0] = quo_q;
    assign rs[0] = rem_q;

    // DIV_STEP restoring steps per clock
    for (genvar k = 0; k < DIV_STEP; k++) begin : g_step
        logic [DEN_W:0] trial;
        logic           take;
        assign trial     = {rs[k], qs[k][NP-1]};
        assign take      = trial >= {1'b0, den_q};
        assign rs[k+1]   = take ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        assign qs[k+1]   = {qs[k][NP-2:0], take};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                quo_q <= NP'(num_i);
                rem_q <= '0;
                den_q <= den_i;
                cnt_q <= CNT_W'(PASSES);
            end else if (cnt_q != '0) begin
                quo_q <= qs[DIV_STEP];
                rem_q <= rs[DIV_STEP];
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) done_o <= 1'b1;
            end
        end
    end

    assign quo_o = NUM_W'(quo_q);

    // R1: remainder of a finished truncating division is below the divisor
    a_r1_rem_bound: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (rem_q < den_q));

    // R1: divider is idle when it reports completion
    a_r1_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cnt_q == '0));

endmodule

// File: rtl/plldiv_sweep.sv
module plldiv_sweep
    import plldiv_pkg::*;
#(
    parameter int unsigned DO_MIN   = 6,
    parameter int unsigned DO_MAX   = 63,
    parameter int unsigned DR_MIN   = 3,
    parameter int unsigned DR_MAX   = 5,
    parameter int unsigned LC_MIN   = 6,
    parameter int unsigned LC_MAX   = 160,
    parameter int unsigned RATIO_LO = 12,
    parameter int unsigned RATIO_HI = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     init_i,
    input  logic     step_i,
    output pll_cfg_t cfg_o,
    output logic     new_ref_o,
    output logic     last_o
);
    localparam logic [DO_W-1:0] DO_FIRST = DO_W'(DO_MIN);
    localparam logic [DO_W-1:0] DO_LAST  = DO_W'(DO_MAX);
    localparam logic [DR_W-1:0] DR_FIRST = DR_W'(DR_MIN);
    localparam logic [DR_W-1:0] DR_LAST  = DR_W'(DR_MAX);
    localparam logic [LC_W-1:0] LC_START = win_lo(DR_MIN, LC_MIN, RATIO_LO);

    logic [DO_W-1:0] do_q;
    logic [DR_W-1:0] dr_q;
    logic [LC_W-1:0] lc_q;
    logic [LC_W-1:0] lo_cur, hi_cur, lo_next;
    logic            lc_end, dr_end, do_end;

    always_comb begin
        lo_cur  = win_lo(32'(dr_q), LC_MIN, RATIO_LO);
        hi_cur  = win_hi(32'(dr_q), LC_MAX, RATIO_HI);
        lo_next = win_lo(32'(dr_q) + 1, LC_MIN, RATIO_LO);
        lc_end  = lc_q >= hi_cur;
        dr_end  = dr_q == DR_LAST;
        do_end  = do_q == DO_LAST;
    end

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            do_q <= DO_FIRST;
            dr_q <= DR_FIRST;
            lc_q <= LC_START;
        end else if (step_i) begin
            if (!lc_end) begin
                lc_q <= lc_q + 1'b1;
            end else if (!dr_end) begin
                dr_q <= dr_q + 1'b1;
                lc_q <= lo_next;
            end else if (!do_end) begin
                do_q <= do_q + 1'b1;
                dr_q <= DR_FIRST;
                lc_q <= LC_START;
            end
        end
    end

    assign cfg_o     = '{dout: do_q, dref: dr_q, mult: lc_q};
    assign new_ref_o = lc_end;
    assign last_o    = lc_end && dr_end && do_end;

    // R3: the presented multiplier always sits inside the ratio window
    a_r3_window: assert property (@(posedge clk) disable iff (rst)
        (lc_q >= lo_cur) && (lc_q <= hi_cur));

    // R2: dividers stay inside their sweep ranges
    a_r2_ranges: assert property (@(posedge clk) disable iff (rst)
        (do_q >= DO_FIRST) && (do_q <= DO_LAST) && (dr_q >= DR_FIRST) && (dr_q <= DR_LAST));

endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
    import plldiv_pkg::*;
#(
    parameter int unsigned FREQ_W   = 20,
    parameter int unsigned TOL_KHZ  = 1000,
    parameter int unsigned DIV_STEP = 14,
    parameter int unsigned DO_MIN   = 6,
    parameter int unsigned DO_MAX   = 63,
    parameter int unsigned DR_MIN   = 3,
    parameter int unsigned DR_MAX   = 5,
    parameter int unsigned LC_MIN   = 6,
    parameter int unsigned LC_MAX   = 160,
    parameter int unsigned RATIO_LO = 12,
    parameter int unsigned RATIO_HI = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [FREQ_W-1:0]     target_khz_i,
    input  logic [FREQ_W-1:0]     ref_khz_i,
    output logic                  done_o,
    output logic                  found_o,
    output logic [5:0]            div_out_o,
    output logic [2:0]            div_ref_o,
    output logic [7:0]            mult_o,
    output logic [FREQ_W+7:0]     err_khz_o
);
    localparam int unsigned      PROD_W = FREQ_W + LC_W;
    localparam logic [PROD_W-1:0] TOL    = PROD_W'(TOL_KHZ);

    srch_state_t      st;
    logic [PROD_W-1:0] tgt_q, ref_q, q1_q, best_err_q;
    pll_cfg_t          best_cfg_q, cur_cfg;

    logic              sw_init, sw_step, sw_new_ref, sw_last;
    logic              div_go, div_done;
    logic [PROD_W-1:0] div_num, div_quo;
    logic [DO_W-1:0]   div_den;

    logic [PROD_W-1:0] cand_err, fin_err;
    pll_cfg_t          fin_cfg;
    logic              eval, better, exact;

    plldiv_sweep #(
        .DO_MIN(DO_MIN), .DO_MAX(DO_MAX), .DR_MIN(DR_MIN), .DR_MAX(DR_MAX),
        .LC_MIN(LC_MIN), .LC_MAX(LC_MAX), .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)
    ) u_sweep (
        .clk(clk), .rst(rst), .init_i(sw_init), .step_i(sw_step),
        .cfg_o(cur_cfg), .new_ref_o(sw_new_ref), .last_o(sw_last)
    );

    plldiv_divider #(
        .NUM_W(PROD_W), .DEN_W(DO_W), .DIV_STEP(DIV_STEP)
    ) u_div (
        .clk(clk), .rst(rst), .go_i(div_go), .num_i(div_num), .den_i(div_den),
        .done_o(div_done), .quo_o(div_quo)
    );

    always_comb begin
        div_go  = (st == S_REF) || (st == S_OUT);
        div_num = (st == S_REF) ? ref_q : q1_q * PROD_W'(cur_cfg.mult);
        div_den = (st == S_REF) ? DO_W'(cur_cfg.dref) : cur_cfg.dout;
        cand_err = (tgt_q >= div_quo) ? (tgt_q - div_quo) : (div_quo - tgt_q);
        eval    = (st == S_OUT_WAIT) && div_done;
        better  = cand_err < best_err_q;
        exact   = cand_err == '0;
        fin_err = better ? cand_err : best_err_q;
        fin_cfg = better ? cur_cfg : best_cfg_q;
        sw_init = (st == S_IDLE) && start_i;
        sw_step = eval && !exact && !sw_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            tgt_q      <= '0;
            ref_q      <= '0;
            q1_q       <= '0;
            best_err_q <= '0;
            best_cfg_q <= '0;
            done_o     <= 1'b0;
            found_o    <= 1'b0;
            div_out_o  <= '0;
            div_ref_o  <= '0;
            mult_o     <= '0;
            err_khz_o  <= '0;
        end else begin
            done_o <= 1'b0;
            case (st)
                S_IDLE: if (start_i) begin
                    tgt_q      <= PROD_W'(target_khz_i);
                    ref_q      <= PROD_W'(ref_khz_i);
                    best_err_q <= TOL;
                    best_cfg_q <= '0;
                    st         <= S_REF;
                end
                S_REF:      st <= S_REF_WAIT;
                S_REF_WAIT: if (div_done) begin
                    q1_q <= div_quo;
                    st   <= S_OUT;
                end
                S_OUT:      st <= S_OUT_WAIT;
                S_OUT_WAIT: if (div_done) begin
                    best_err_q <= fin_err;
                    best_cfg_q <= fin_cfg;
                    if (exact || sw_last) begin
                        done_o    <= 1'b1;
                        found_o   <= fin_err < TOL;
                        err_khz_o <= fin_err;
                        div_out_o <= fin_cfg.dout;
                        div_ref_o <= fin_cfg.dref;
                        mult_o    <= fin_cfg.mult;
                        st        <= S_IDLE;
                    end else begin
                        st <= sw_new_ref ? S_REF : S_OUT;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R8: done lasts a single cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: a found result is under tolerance
    a_r6_found_tol: assert property (@(posedge clk) disable iff (rst)
        (done_o && found_o) |-> (err_khz_o < TOL));

    // R6: a rejected result reports exactly the tolerance
    a_r6_miss_tol: assert property (@(posedge clk) disable iff (rst)
        (done_o && !found_o) |-> (err_khz_o == TOL));

    // R4: the stored best never rises within a search
    a_r4_best_monotone: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE) |=> (best_err_q <= $past(best_err_q)));

    // R9: a start during a search leaves the latched target alone
    a_r9_busy_start: assert property (@(posedge clk) disable iff (rst)
        ((st != S_IDLE) && start_i) |=> $stable(tgt_q) && $stable(ref_q));

    // R10: results hold while idle without a start
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        ((st == S_IDLE) && !start_i) |=> $stable(found_o) && $stable(err_khz_o)
            && $stable(div_out_o) && $stable(div_ref_o) && $stable(mult_o));

endmodule

// File: tb/test_pll_param_search.sv
module test_pll_param_search;
    localparam int FREQ_W = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [FREQ_W-1:0] target_khz_i = '0;
    logic [FREQ_W-1:0] ref_khz_i = '0;
    logic              done_o, found_o;
    logic [5:0]        div_out_o;
    logic [2:0]        div_ref_o;
    logic [7:0]        mult_o;
    logic [FREQ_W+7:0] err_khz_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pll_param_search i_pll_param_search (
        .clk(clk), .rst(rst), .start_i(start_i),
        .target_khz_i(target_khz_i), .ref_khz_i(ref_khz_i),
        .done_o(done_o), .found_o(found_o), .div_out_o(div_out_o),
        .div_ref_o(div_ref_o), .mult_o(mult_o), .err_khz_o(err_khz_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // independent model of the search from the requirements
    task automatic model(input int tgt, input int refk, output int e_do, output int e_dr,
                         output int e_lc, output int e_err, output int e_found);
        int best, bd, br, bl, hit;
        best = 1000; bd = 0; br = 0; bl = 0; hit = 0;
        for (int d = 6; d <= 63 && hit == 0; d++) begin
            for (int r = 3; r <= 5 && hit == 0; r++) begin
                for (int m = 6; m <= 160 && hit == 0; m++) begin
                    int c, df;
                    if (m < 12 * r || m > 32 * r) continue;
                    c  = refk / r * m / d;
                    df = (tgt >= c) ? tgt - c : c - tgt;
                    if (df < best) begin
                        best = df; bd = d; br = r; bl = m;
                        if (df == 0) hit = 1;
                    end
                end
            end
        end
        e_do = bd; e_dr = br; e_lc = bl; e_err = best;
        e_found = (best < 1000) ? 1 : 0;
    endtask

    task automatic pulse_start(input int tgt, input int refk);
        @(negedge clk);
        target_khz_i = FREQ_W'(tgt);
        ref_khz_i    = FREQ_W'(refk);
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (done_o !== 1'b1 && lat < 80000) begin
            @(negedge clk);
            lat++;
        end
        if (done_o !== 1'b1) check("watchdog search", 0, 1);
    endtask

    task automatic check_result(input string req, input int tgt, input int refk);
        int e_do, e_dr, e_lc, e_err, e_found;
        model(tgt, refk, e_do, e_dr, e_lc, e_err, e_found);
        check({req, " found"}, found_o, e_found);
        check({req, " err"}, err_khz_o, e_err);
        check({req, " div_out"}, div_out_o, e_do);
        check({req, " div_ref"}, div_ref_o, e_dr);
        check({req, " mult"}, mult_o, e_lc);
        @(negedge clk);
        check("R8 done single cycle", done_o, 0);
    endtask

    task automatic t_reset();
        check("R10 reset done", done_o, 0);
        check("R10 reset found", found_o, 0);
        check("R10 reset err", err_khz_o, 0);
        check("R10 reset params", {div_out_o, div_ref_o, mult_o}, 0);
    endtask

    task automatic t_first_hit();
        int lat;
        pulse_start(199998, 100000);
        wait_done(lat);
        check("R5 early stop latency", (lat <= 20) ? 1 : 0, 1);
        check("R1 truncated order err", err_khz_o, 0);
        check_result("R1 R5 first candidate", 199998, 100000);
    endtask

    task automatic t_order();
        int lat;
        pulse_start(200000, 100000);
        wait_done(lat);
        check("R2 middle loop hit div_ref", div_ref_o, 4);
        check_result("R2 R3 order", 200000, 100000);
    endtask

    task automatic t_other_ref();
        int lat;
        pulse_start(120000, 60000);
        wait_done(lat);
        check_result("R11 ref 60000", 120000, 60000);
    endtask

    task automatic t_inexact();
        int lat;
        pulse_start(25175, 100000);
        wait_done(lat);
        check_result("R4 R6 R7 closest", 25175, 100000);
    endtask

    task automatic t_busy_miss();
        int lat;
        pulse_start(900000, 100000);
        repeat (50) @(negedge clk);
        pulse_start(199998, 100000);
        wait_done(lat);
        check("R9 busy start ignored found", found_o, 0);
        check("R6 miss err", err_khz_o, 1000);
        check_result("R6 R9 miss", 900000, 100000);
    endtask

    task automatic t_hold();
        logic [FREQ_W+7:0] e0;
        logic [16:0] p0;
        logic f0;
        e0 = err_khz_o; p0 = {div_out_o, div_ref_o, mult_o}; f0 = found_o;
        target_khz_i = FREQ_W'(199998);
        ref_khz_i    = FREQ_W'(60000);
        repeat (20) @(negedge clk);
        check("R10 hold err", err_khz_o, e0);
        check("R10 hold params", {div_out_o, div_ref_o, mult_o}, p0);
        check("R10 hold found", found_o, f0);
        check("R10 no done", done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_hit();
        t_order();
        t_other_ref();
        t_hold();
        t_busy_miss();
        t_hold();
        t_inexact();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc >= 195000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=<195000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule